// File: doc/BRIEF.md
# SPI Master Transfer Sequencer

This block is the control engine of an SPI master. Software programs a timing word and a frame word, then writes a command word to start a run. The engine asserts chip select, waits a setup time and clocks bytes out and in, MSB first. It then waits a hold time, releases chip select and waits an idle gap before it accepts the next start. The SCK high time and low time are set separately, and the clock polarity and phase come from the command word.

A run is a number of packets. Each packet has a programmed number of bytes. Every byte is full duplex: the engine pops one transmit byte from an external byte source and delivers one received byte with a valid strobe to an external byte sink. If pause is enabled, the engine stops after a run with chip select still asserted and waits in a paused state. A resume command then starts another run without releasing chip select. A run completion can raise an interrupt, which stays high until software reads the status word. A soft-reset command bit returns the engine to idle from any state.

Register map (32-bit words, 2-bit address):
- Word 0, timing: [7:0] SCK high, [15:8] SCK low, [23:16] CS setup, [31:24] CS hold. Each field holds cycles minus one.
- Word 1, frame: [9:0] bytes per packet minus one, [23:16] packet count minus one, [31:24] CS idle cycles minus one.
- Word 2, command: bits 0 to 2 are write-only pulses that read as 0; bits 3 to 6 are stored.
- Word 3, status: read-only.

Top module: `spi_xfer_seq`

## Requirements
- R1: Writing word 2 with bit 0 set while idle pulls cs_no low. CS then stays low for (setup+1) + bytes*8*((high+1)+(low+1)) + (hold+1) cycles. Setup is word 0 bits 23:16 and hold is word 0 bits 31:24.
- R2: During bit transfer SCK stays high for (word 0 bits 7:0)+1 cycles per high phase. It stays low for (word 0 bits 15:8)+1 cycles between two high phases.
- R3: After cs_no rises, status bit 0 (busy) stays 1 for (word 1 bits 31:24)+1 cycles, then the engine is idle.
- R4: A run transfers (word 1 bits 9:0 + 1) * (word 1 bits 23:16 + 1) bytes. It pulses tx_pop_o once and rx_valid_o once per byte.
- R5: Each byte is full duplex and MSB first. The popped tx byte is shifted out on mosi_o, and the bits sampled from miso_i form the byte presented on rx_data_o.
- R6: Command bit 3 (CPOL) is the SCK level whenever cs_no is high. With command bit 4 (CPHA) at 0, data is sampled on the leading SCK edge and changed on the trailing edge. With CPHA at 1, data is changed on the leading edge and sampled on the trailing edge.
- R7: With command bit 5 (pause enable) set, a run ends in the paused state: cs_no stays low, status bit 1 is 1 and status bit 0 is 0. Writing command bit 1 (resume) then runs another run, and cs_no does not rise.
- R8: With command bit 6 set, irq_o and status bit 2 rise when a run completes, whether it ends idle or paused. A read of word 3 clears them. With bit 6 clear, irq_o stays low.
- R9: Writing command bit 2 (soft reset) returns the engine to idle from any state: cs_no high, irq_o low, status bits 2:0 zero.
- R10: A start command is ignored unless the engine is idle. A resume command is ignored unless the engine is paused.
- R11: After rst_ni is released: cs_no high, sck_o low, irq_o low, status bits 2:0 zero, no tx_pop_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (clears the interrupt when reading word 3) |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on address |
| irq_o | output | 1 | Run-complete interrupt, level |
| tx_data_i | input | 8 | Next transmit byte from the byte source |
| tx_pop_o | output | 1 | Transmit byte taken this cycle |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | rx_data_o valid for one cycle |
| sck_o | output | 1 | SPI serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
A wrong sequencer state shows up within one cycle at cs_no or at the busy and paused status bits, as a CS window or idle gap whose length differs from the programmed sum. A wrong byte or loop counter gives a pop count or rx_valid count that differs from length times loop at the end of the run. A wrong half-phase counter or edge choice gives SCK pulse widths that differ from the programmed values. It also breaks the data exchange with a mode-aware slave model, so the byte that arrives at the sink or at the slave is wrong by the end of that byte.

// File: rtl/spi_xfer_seq_pkg.sv
package spi_xfer_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_XFER, ST_HOLD, ST_GAP, ST_PAUSED
  } seq_state_e;

  localparam logic [1:0] ADDR_TIMING = 2'd0;
  localparam logic [1:0] ADDR_FRAME  = 2'd1;
  localparam logic [1:0] ADDR_CMD    = 2'd2;
  localparam logic [1:0] ADDR_STAT   = 2'd3;

  localparam int unsigned CMD_START  = 0;
  localparam int unsigned CMD_RESUME = 1;
  localparam int unsigned CMD_SRST   = 2;
  localparam int unsigned CMD_CPOL   = 3;
  localparam int unsigned CMD_CPHA   = 4;
  localparam int unsigned CMD_PAUSE  = 5;
  localparam int unsigned CMD_IRQEN  = 6;
endpackage

// File: rtl/spi_xfer_seq_regs.sv
module spi_xfer_seq_regs
  import spi_xfer_seq_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             busy_i,
  input  logic             paused_i,
  input  logic             run_done_i,
  output logic [REG_W-1:0] timing_o,
  output logic [REG_W-1:0] frame_o,
  output logic             cpol_o,
  output logic             cpha_o,
  output logic             pause_en_o,
  output logic             start_o,
  output logic             resume_o,
  output logic             srst_o,
  output logic             irq_o
);
  logic [REG_W-1:0] timing_q, frame_q, cmd_q;
  logic             irq_q, cmd_wr;

  assign cmd_wr   = we_i && (addr_i == ADDR_CMD);
  assign start_o  = cmd_wr && wdata_i[CMD_START];
  assign resume_o = cmd_wr && wdata_i[CMD_RESUME];
  assign srst_o   = cmd_wr && wdata_i[CMD_SRST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timing_q <= '0;
      frame_q  <= '0;
      cmd_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (we_i && addr_i == ADDR_TIMING) timing_q <= wdata_i;
      if (we_i && addr_i == ADDR_FRAME)  frame_q  <= wdata_i;
      if (cmd_wr) begin
        cmd_q <= wdata_i;
        // pulse bits are not stored
        cmd_q[CMD_SRST:CMD_START] <= '0;
      end
      if (srst_o)                                 irq_q <= 1'b0;
      else if (run_done_i && cmd_q[CMD_IRQEN])    irq_q <= 1'b1;
      else if (re_i && addr_i == ADDR_STAT)       irq_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_TIMING: rdata_o = timing_q;
      ADDR_FRAME:  rdata_o = frame_q;
      ADDR_CMD:    rdata_o = cmd_q;
      default:     rdata_o = {{(REG_W-3){1'b0}}, irq_q, paused_i, busy_i};
    endcase
  end

  assign timing_o   = timing_q;
  assign frame_o    = frame_q;
  assign cpol_o     = cmd_q[CMD_CPOL];
  assign cpha_o     = cmd_q[CMD_CPHA];
  assign pause_en_o = cmd_q[CMD_PAUSE];
  assign irq_o      = irq_q;
endmodule

// File: rtl/spi_xfer_seq_bits.sv
module spi_xfer_seq_bits #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              run_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [TW-1:0]     hi_i,
  input  logic [TW-1:0]     lo_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int unsigned BIT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sh_q, rx_q;
  logic [BIT_W-1:0]  bit_q;
  logic              half_q;
  logic [TW-1:0]     cnt_q, dur0, dur1;
  logic              lvl0;

  // level of the first half of each bit; sampling always at its end
  assign lvl0   = cpol_i ^ cpha_i;
  assign dur0   = lvl0 ? hi_i : lo_i;
  assign dur1   = lvl0 ? lo_i : hi_i;
  assign done_o = run_i && (cnt_q == '0) && half_q && (bit_q == '0);
  assign sck_o  = run_i ? (half_q ? ~lvl0 : lvl0) : cpol_i;
  assign mosi_o = sh_q[DATA_W-1];
  assign rx_o   = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      half_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      sh_q   <= data_i;
      bit_q  <= BIT_W'(DATA_W-1);
      half_q <= 1'b0;
      cnt_q  <= dur0;
    end else if (run_i) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (!half_q) begin
        rx_q   <= {rx_q[DATA_W-2:0], miso_i};
        half_q <= 1'b1;
        cnt_q  <= dur1;
      end else if (bit_q != '0) begin
        sh_q   <= sh_q << 1;
        bit_q  <= bit_q - 1'b1;
        half_q <= 1'b0;
        cnt_q  <= dur0;
      end
    end
  end
endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_xfer_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TW     = 8,
  parameter int unsigned LEN_W  = 10,
  parameter int unsigned LOOP_W = 8,
  parameter int unsigned REG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int unsigned HI_LSB    = 0;
  localparam int unsigned LO_LSB    = TW;
  localparam int unsigned SETUP_LSB = 2*TW;
  localparam int unsigned HOLD_LSB  = 3*TW;
  localparam int unsigned LEN_LSB   = 0;
  localparam int unsigned LOOP_LSB  = 16;
  localparam int unsigned IDLE_LSB  = 24;

  seq_state_e        st_q;
  logic [TW-1:0]     tmr_q;
  logic [LEN_W-1:0]  byte_q;
  logic [LOOP_W-1:0] loop_q;
  logic [DATA_W-1:0] rx_data_q, rx_byte;
  logic              rx_valid_q;

  logic [REG_W-1:0]  timing, frame;
  logic              cpol, cpha, pause_en, start_p, resume_p, srst_p;
  logic              busy, paused, run_done, load, byte_done, last_byte, run_en;

  logic [TW-1:0]     sck_hi, sck_lo, cs_setup, cs_hold, cs_idle;
  logic [LEN_W-1:0]  pkt_len;
  logic [LOOP_W-1:0] pkt_loop;

  assign sck_hi   = timing[HI_LSB    +: TW];
  assign sck_lo   = timing[LO_LSB    +: TW];
  assign cs_setup = timing[SETUP_LSB +: TW];
  assign cs_hold  = timing[HOLD_LSB  +: TW];
  assign pkt_len  = frame[LEN_LSB    +: LEN_W];
  assign pkt_loop = frame[LOOP_LSB   +: LOOP_W];
  assign cs_idle  = frame[IDLE_LSB   +: TW];

  assign busy      = (st_q != ST_IDLE) && (st_q != ST_PAUSED);
  assign paused    = (st_q == ST_PAUSED);
  assign run_en    = (st_q == ST_XFER);
  assign last_byte = (byte_q == pkt_len) && (loop_q == pkt_loop);
  assign load      = !srst_p && (((st_q == ST_SETUP) && (tmr_q == '0)) ||
                                 (run_en && byte_done && !last_byte));
  assign run_done  = !srst_p && (st_q == ST_HOLD) && (tmr_q == '0);
  assign cs_no     = (st_q == ST_IDLE) || (st_q == ST_GAP);
  assign tx_pop_o  = load;
  assign rx_data_o = rx_data_q;
  assign rx_valid_o = rx_valid_q;

  spi_xfer_seq_regs #(.REG_W(REG_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .paused_i(paused), .run_done_i(run_done),
    .timing_o(timing), .frame_o(frame),
    .cpol_o(cpol), .cpha_o(cpha), .pause_en_o(pause_en),
    .start_o(start_p), .resume_o(resume_p), .srst_o(srst_p), .irq_o(irq_o)
  );

  spi_xfer_seq_bits #(.DATA_W(DATA_W), .TW(TW)) u_bits (
    .clk_i, .rst_ni,
    .load_i(load), .data_i(tx_data_i), .run_i(run_en),
    .cpol_i(cpol), .cpha_i(cpha), .hi_i(sck_hi), .lo_i(sck_lo),
    .miso_i, .sck_o, .mosi_o, .done_o(byte_done), .rx_o(rx_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      tmr_q      <= '0;
      byte_q     <= '0;
      loop_q     <= '0;
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      if (srst_p) begin
        st_q  <= ST_IDLE;
        tmr_q <= '0;
      end else begin
        unique case (st_q)
          ST_IDLE: if (start_p) begin
            st_q   <= ST_SETUP;
            tmr_q  <= cs_setup;
            byte_q <= '0;
            loop_q <= '0;
          end
          ST_SETUP: if (tmr_q == '0) st_q <= ST_XFER;
                    else             tmr_q <= tmr_q - 1'b1;
          ST_XFER: if (byte_done) begin
            rx_data_q  <= rx_byte;
            rx_valid_q <= 1'b1;
            if (last_byte) begin
              st_q  <= ST_HOLD;
              tmr_q <= cs_hold;
            end else if (byte_q == pkt_len) begin
              byte_q <= '0;
              loop_q <= loop_q + 1'b1;
            end else begin
              byte_q <= byte_q + 1'b1;
            end
          end
          ST_HOLD: if (tmr_q == '0) begin
            st_q  <= pause_en ? ST_PAUSED : ST_GAP;
            tmr_q <= cs_idle;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
          ST_GAP: if (tmr_q == '0) st_q <= ST_IDLE;
                  else             tmr_q <= tmr_q - 1'b1;
          ST_PAUSED: if (resume_p) begin
            // CS already asserted: one cycle, then bits
            st_q   <= ST_SETUP;
            tmr_q  <= '0;
            byte_q <= '0;
            loop_q <= '0;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_xfer_seq_chk.sv
module spi_xfer_seq_chk
  import spi_xfer_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       sck_i,
  input logic       irq_i,
  input logic       pop_i,
  input logic       cpol_i,
  input logic       start_i,
  input logic       resume_i,
  input logic       srst_i,
  input seq_state_e st_i
);
  // R6
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (sck_i == cpol_i));

  // R4
  pop_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !cs_ni);

  // R8
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> ($past(st_i) == ST_HOLD));

  // R9
  srst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (cs_ni && !irq_i));

  // R10
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (st_i == ST_XFER || st_i == ST_HOLD || st_i == ST_GAP))
      |=> (st_i != ST_SETUP));

  // R7
  pause_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_PAUSED && !resume_i && !srst_i) |=> (st_i == ST_PAUSED && !cs_ni));
endmodule

bind spi_xfer_seq spi_xfer_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_ni   (cs_no),
  .sck_i   (sck_o),
  .irq_i   (irq_o),
  .pop_i   (tx_pop_o),
  .cpol_i  (cpol),
  .start_i (start_p),
  .resume_i(resume_p),
  .srst_i  (srst_p),
  .st_i    (st_q)
);

// File: tb/spi_xfer_seq_tb.sv
module spi_xfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0]  reg_addr = 2'd3;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, tx_pop, rx_valid, sck, cs_n, mosi, miso;
  logic [7:0]  tx_data, rx_data;

  int errors = 0, checks = 0;
  int pop_idx = 0;
  int exp_base = 0;
  logic [7:0] exp_rx[$];
  logic [7:0] exp_tx[$];
  logic cpol_m = 1'b0, cpha_m = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] tx_byte(int k);
    return 8'(k * 13) ^ 8'h5A;
  endfunction
  function automatic logic [7:0] slv_byte(int k);
    return 8'(8'hC3 + k * 29);
  endfunction

  spi_xfer_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .tx_data_i(tx_data), .tx_pop_o(tx_pop),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .sck_o(sck), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  assign tx_data = tx_byte(pop_idx);
  always @(posedge clk) if (tx_pop) pop_idx <= pop_idx + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slave model: captures mosi and drives miso per CPOL/CPHA
  int   s_p = 0, s_n = 0;
  logic [7:0] s_sh = '0;
  logic s_prev = 1'b0, miso_r = 1'b0, lead;
  function automatic logic sbit(int p);
    logic [7:0] b;
    b = slv_byte(p / 8);
    return b[7 - (p % 8)];
  endfunction
  assign miso = cpha_m ? miso_r : sbit(s_p);

  always @(negedge clk) begin
    if (cs_n) s_prev = sck;
    else if (sck != s_prev) begin
      lead = (s_prev == cpol_m);
      s_prev = sck;
      if (lead ^ cpha_m) begin
        s_sh = {s_sh[6:0], mosi};
        s_n++;
        if (s_n == 8) begin
          s_n = 0;
          if (exp_tx.size() == 0) chk(1'b0, "R5 slave extra byte", s_sh, 0);
          else begin
            logic [7:0] e;
            e = exp_tx.pop_front();
            chk(s_sh == e, "R5 mosi byte", s_sh, e);
          end
        end
      end else begin
        if (cpha_m) miso_r = sbit(s_p);
        s_p++;
      end
    end
  end

  // monitor: scoreboard pop and window measurements
  int cs_low_cnt = 0, last_cs_low = 0, gap_cnt = 0, cs_rises = 0;
  int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0, idle_err = 0;
  int pops = 0, rxv = 0;
  bit seen_hi = 0, cs_prev = 1;
  always @(negedge clk) begin
    #1;
    if (rst_ni) begin
      if (tx_pop) pops++;
      if (rx_valid) begin
        rxv++;
        if (exp_rx.size() == 0) chk(1'b0, "R5 extra rx byte", rx_data, 0);
        else begin
          logic [7:0] e;
          e = exp_rx.pop_front();
          chk(rx_data == e, "R5 rx byte", rx_data, e);
        end
      end
      if (!cs_n) begin
        if (cs_prev) begin
          cs_low_cnt = 0; gap_cnt = 0; seen_hi = 0; hi_run = 0; lo_run = 0;
        end
        cs_low_cnt++;
        if (sck) begin
          if (lo_run > 0 && seen_hi) last_lo = lo_run;
          lo_run = 0; hi_run++; seen_hi = 1;
        end else begin
          if (hi_run > 0) last_hi = hi_run;
          hi_run = 0; lo_run++;
        end
      end else begin
        if (!cs_prev) begin
          last_cs_low = cs_low_cnt;
          cs_rises++;
        end
        if (reg_addr == 2'd3 && reg_rdata[0]) gap_cnt++;
        if (sck != cpol_m) idle_err++;
      end
      cs_prev = cs_n;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd3;
  endtask

  task automatic peek(output logic [31:0] d);
    @(negedge clk);
    reg_addr = 2'd3;
    #1 d = reg_rdata;
  endtask

  task automatic rd_status(output logic [31:0] d);
    @(negedge clk);
    reg_addr = 2'd3; reg_re = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic expect_bytes(input int n);
    for (int k = 0; k < n; k++) begin
      exp_rx.push_back(slv_byte(exp_base));
      exp_tx.push_back(tx_byte(exp_base));
      exp_base++;
    end
  endtask

  task automatic wait_rest();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      #2;
      if (!reg_rdata[0] && (cs_n || reg_rdata[1])) break;
    end
  endtask

  task automatic set_mode(input logic [31:0] m);
    wr(2'd2, m);
    cpol_m = m[3];
    cpha_m = m[4];
  endtask

  task automatic run_all();
    logic [31:0] d;
    int p0, r0, c0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    peek(d);
    // R11
    chk(cs_n == 1'b1, "R11 cs_no after reset", cs_n, 1);
    chk(sck == 1'b0 && irq == 1'b0 && tx_pop == 1'b0, "R11 sck/irq/pop after reset",
        {sck, irq, tx_pop}, 0);
    chk(d[2:0] == 3'b000, "R11 status after reset", d[2:0], 0);

    // mode 0, 3 bytes x 2 packets, irq on
    wr(2'd0, 32'h04030102);
    wr(2'd1, 32'h05010002);
    set_mode(32'h40);
    expect_bytes(6);
    p0 = pops; r0 = rxv;
    wr(2'd2, 32'h41);
    repeat (20) @(negedge clk);
    wr(2'd2, 32'h41);   // R10 start while busy
    wait_rest();
    chk(pops - p0 == 6, "R4 R10 pops per run", pops - p0, 6);
    chk(rxv - r0 == 6, "R4 rx_valid per run", rxv - r0, 6);
    chk(last_cs_low == 249, "R1 cs low window", last_cs_low, 249);
    chk(last_hi == 3, "R2 sck high width", last_hi, 3);
    chk(last_lo == 2, "R2 sck low width", last_lo, 2);
    chk(gap_cnt == 6, "R3 idle gap", gap_cnt, 6);
    chk(irq == 1'b1, "R8 irq at run end", irq, 1);
    rd_status(d);
    chk(d[2] == 1'b1, "R8 status irq bit", d[2], 1);
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq cleared by read", irq, 0);

    // mode 3, 1 byte x 4 packets, minimal timing, irq off
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h00030000);
    set_mode(32'h18);
    expect_bytes(4);
    p0 = pops;
    wr(2'd2, 32'h19);
    wait_rest();
    chk(last_cs_low == 66, "R1 cs low window min timing", last_cs_low, 66);
    chk(pops - p0 == 4, "R4 pops with loop count", pops - p0, 4);
    chk(irq == 1'b0, "R8 irq stays low when disabled", irq, 0);

    // modes 1 and 2
    wr(2'd1, 32'h00000001);
    set_mode(32'h10);
    expect_bytes(2);
    wr(2'd2, 32'h11);
    wait_rest();
    set_mode(32'h08);
    expect_bytes(2);
    wr(2'd2, 32'h09);
    wait_rest();
    chk(idle_err == 0, "R6 sck idle level", idle_err, 0);

    // pause and resume
    wr(2'd0, 32'h01010101);
    set_mode(32'h60);
    expect_bytes(2);
    p0 = pops; c0 = cs_rises;
    wr(2'd2, 32'h61);
    wait_rest();
    peek(d);
    chk(d[1:0] == 2'b10, "R7 paused status", d[1:0], 2);
    chk(cs_n == 1'b0, "R7 cs held in pause", cs_n, 0);
    chk(irq == 1'b1, "R8 irq on paused end", irq, 1);
    rd_status(d);
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq cleared in pause", irq, 0);
    wr(2'd2, 32'h61);   // R10 start while paused
    repeat (10) @(negedge clk);
    peek(d);
    chk(pops - p0 == 2 && d[1:0] == 2'b10, "R10 start ignored when paused", pops - p0, 2);
    expect_bytes(2);
    wr(2'd2, 32'h62);
    wait_rest();
    peek(d);
    chk(pops - p0 == 4, "R7 resume runs again", pops - p0, 4);
    chk(cs_rises == c0, "R7 cs never released", cs_rises - c0, 0);
    chk(d[1] == 1'b1 && irq == 1'b1, "R7 R8 paused again with irq", {d[1], irq}, 3);
    wr(2'd2, 32'h64);
    peek(d);
    chk(cs_n == 1'b1 && irq == 1'b0, "R9 soft reset cs/irq", {cs_n, irq}, 2);
    chk(d[2:0] == 3'b000, "R9 soft reset status", d[2:0], 0);

    // resume while idle
    p0 = pops;
    wr(2'd2, 32'h02);
    repeat (5) @(negedge clk);
    peek(d);
    chk(cs_n == 1'b1 && d[1:0] == 2'b00 && pops == p0, "R10 resume ignored in idle",
        d[1:0], 0);

    repeat (5) @(negedge clk);
    chk(exp_rx.size() == 0, "R5 rx scoreboard drained", exp_rx.size(), 0);
    chk(exp_tx.size() == 0, "R5 tx scoreboard drained", exp_tx.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule